// File: doc/BRIEF.md
# Packed Compare Select ALU

This unit operates on two 64-bit operands as a set of independent lanes of 8, 16 or 32 bits. It compares lanes for equality, for signed or unsigned greater-than, picks the smaller or larger lane under either interpretation, adds or subtracts lanes with wrap-around, and averages byte or halfword lanes with a selectable rounding bit. Compare operations produce a full mask lane (all ones or all zeros), which a later select or logic step can use.

Each cycle the unit samples its inputs and presents the 64-bit result, a packed negative/zero flag word and an illegal-operation indication one clock later. The flag word gives every lane a field of equal width, so its layout follows the lane size. Encodings that have no defined meaning produce a zero result and raise the illegal output instead of returning undefined data.

Top module: `pcs_alu`

## Requirements
- R1: While rst_ni is low, and at the first sample after release with no clock edge taken, res_o, flags_o and illegal_o are all zero.
- R2: Outputs reflect the inputs sampled at the previous rising clock edge; they change only at rising edges, one cycle after the inputs are applied.
- R3: Opcode 0 (equal) sets a lane to all ones when the A and B lanes are equal and to all zeros otherwise. Lane size code 0 = 8-bit, 1 = 16-bit, 2 = 32-bit lanes; lane i occupies bits [i*W +: W].
- R4: Opcode 1 (signed greater) and opcode 2 (unsigned greater) write an all-ones lane when A > B, interpreting each lane at its own width in two's complement or unsigned form respectively, and all zeros otherwise.
- R5: Opcodes 3 (signed min), 4 (unsigned min), 5 (signed max) and 6 (unsigned max) copy the selected operand's lane unchanged into the result lane.
- R6: Opcode 7 (add) and opcode 8 (subtract, A - B) wrap modulo 2^W per lane; no carry or borrow crosses into a neighbouring lane.
- R7: Opcode 9 (average) yields (A + B + rnd_i) >> 1 per lane, with the sum formed one bit wider than the lane so the carry is kept; it is defined for lane sizes 0 and 1.
- R8: flags_o gives lane i the field [i*F +: F] with F = 32 / lane count; bit F-1 of the field is the lane's sign bit (N), bit F-2 is set when the result lane is zero (Z), and all other field bits are zero.
- R9: For opcode 9 only Z flags are written; every N flag bit is zero even when the result lane's top bit is set.
- R10: Opcode values 10 to 15, lane size code 3, or opcode 9 with lane size 2 give res_o = 0, flags_o = 0 and illegal_o = 1 in the following cycle; legal combinations give illegal_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code (0 equal .. 9 average) |
| size_i | input | 2 | Lane size code: 0 byte, 1 halfword, 2 word |
| rnd_i | input | 1 | Rounding bit added before the average shift |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B |
| res_o | output | 64 | Registered packed result |
| flags_o | output | 32 | Registered per-lane N/Z flag word |
| illegal_o | output | 1 | Registered illegal-operation indication |

## Verification
Every output bit comes from one register stage, so a wrong lane select, a carry leaking across a lane boundary or a mis-placed flag bit shows on res_o or flags_o exactly one cycle after the operands that provoke it. Operands are chosen with differing top bits at each lane boundary, so a signed/unsigned mix-up or a lane width error flips whole result lanes rather than single bits. The illegal combinations are driven between legal ones, so a stuck illegal_o or a stale result is visible on the very next cycle.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [3:0] {
    OP_EQ   = 4'd0,
    OP_GTS  = 4'd1,
    OP_GTU  = 4'd2,
    OP_MINS = 4'd3,
    OP_MINU = 4'd4,
    OP_MAXS = 4'd5,
    OP_MAXU = 4'd6,
    OP_ADD  = 4'd7,
    OP_SUB  = 4'd8,
    OP_AVG  = 4'd9
  } pcs_op_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_X = 2'd3
  } pcs_size_e;

  localparam int NUM_SIZES = 3;
endpackage

// File: rtl/pcs_lane.sv
module pcs_lane
  import pcs_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   op_i,
  input  logic         rnd_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  logic         gt_s, gt_u, lt_s, lt_u;
  logic [W:0]   avg_sum;

  assign gt_s = $signed(a_i) > $signed(b_i);
  assign gt_u = a_i > b_i;
  assign lt_s = $signed(a_i) < $signed(b_i);
  assign lt_u = a_i < b_i;
  // carry kept in the extra bit before the shift
  assign avg_sum = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, rnd_i};

  always_comb begin
    unique case (op_i)
      OP_EQ:   res_o = (a_i == b_i) ? '1 : '0;
      OP_GTS:  res_o = gt_s ? '1 : '0;
      OP_GTU:  res_o = gt_u ? '1 : '0;
      OP_MINS: res_o = lt_s ? a_i : b_i;
      OP_MINU: res_o = lt_u ? a_i : b_i;
      OP_MAXS: res_o = gt_s ? a_i : b_i;
      OP_MAXU: res_o = gt_u ? a_i : b_i;
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_AVG:  res_o = avg_sum[W:1];
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/pcs_flags.sv
module pcs_flags #(
  parameter int DATA_W = 64,
  parameter int LANES  = 8,
  parameter int FLAG_W = 32
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic              z_only_i,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int W = DATA_W / LANES;
  localparam int F = FLAG_W / LANES;

  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    logic [W-1:0] lane;
    assign lane = res_i[gl*W +: W];
    if (F > 2) begin : g_pad
      assign flags_o[gl*F +: F-2] = '0;
    end
    assign flags_o[gl*F + F-1] = lane[W-1] & ~z_only_i;
    assign flags_o[gl*F + F-2] = (lane == '0);
  end
endmodule

// File: rtl/pcs_alu.sv
module pcs_alu
  import pcs_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic              rnd_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic [DATA_W/2-1:0] flags_o,
  output logic              illegal_o
);
  localparam int FLAG_W = DATA_W / 2;

  logic [DATA_W-1:0] sz_res [NUM_SIZES];
  logic [FLAG_W-1:0] sz_flg [NUM_SIZES];
  logic              z_only;
  logic              illegal_d;
  logic [DATA_W-1:0] res_d;
  logic [FLAG_W-1:0] flg_d;

  assign z_only = (op_i == OP_AVG);

  for (genvar gs = 0; gs < NUM_SIZES; gs++) begin : g_size
    localparam int W     = 8 << gs;
    localparam int LANES = DATA_W / W;
    for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
      pcs_lane #(.W(W)) u_lane (
        .op_i  (op_i),
        .rnd_i (rnd_i),
        .a_i   (a_i[gl*W +: W]),
        .b_i   (b_i[gl*W +: W]),
        .res_o (sz_res[gs][gl*W +: W])
      );
    end
    pcs_flags #(.DATA_W(DATA_W), .LANES(LANES), .FLAG_W(FLAG_W)) u_flags (
      .res_i    (sz_res[gs]),
      .z_only_i (z_only),
      .flags_o  (sz_flg[gs])
    );
  end

  always_comb begin
    illegal_d = (op_i > OP_AVG) || (size_i == SZ_X) ||
                ((op_i == OP_AVG) && (size_i == SZ_W));
    res_d = '0;
    flg_d = '0;
    if (!illegal_d) begin
      unique case (size_i)
        SZ_B:    begin res_d = sz_res[0]; flg_d = sz_flg[0]; end
        SZ_H:    begin res_d = sz_res[1]; flg_d = sz_flg[1]; end
        default: begin res_d = sz_res[2]; flg_d = sz_flg[2]; end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o     <= '0;
      flags_o   <= '0;
      illegal_o <= 1'b0;
    end else begin
      res_o     <= res_d;
      flags_o   <= flg_d;
      illegal_o <= illegal_d;
    end
  end
endmodule

// File: rtl/pcs_alu_chk.sv
module pcs_alu_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        op_i,
  input logic [1:0]        size_i,
  input logic              rnd_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [DATA_W-1:0] res_o,
  input logic [DATA_W/2-1:0] flags_o,
  input logic              illegal_o
);
  a_r10_illegal_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (res_o == '0 && flags_o == '0));

  a_r10_bad_op_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > 4'd9 || size_i == 2'd3) |=> illegal_o);

  a_r3_eq_all_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd0 && size_i != 2'd3 && a_i == b_i) |=> (res_o == '1));

  a_r6_word_add_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd7 && size_i == 2'd2) |=>
      (res_o[31:0] == 32'($past(a_i[31:0]) + $past(b_i[31:0]))));

  a_r9_avg_byte_no_n: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd9 && size_i == 2'd0) |=> ((flags_o & 32'h8888_8888) == '0));

  a_r9_avg_half_no_n: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd9 && size_i == 2'd1) |=> ((flags_o & 32'h8080_8080) == '0));

  a_r8_byte_z_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i <= 4'd9 && size_i == 2'd0) |=> ((res_o[7:0] == 8'd0) == flags_o[2]));
endmodule

bind pcs_alu pcs_alu_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_pcs_alu.sv
module tb_pcs_alu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic        rnd_i = 1'b0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic [63:0] res_o;
  logic [31:0] flags_o;
  logic        illegal_o;

  int n_run = 0;
  int n_fail = 0;

  pcs_alu dut (.*);

  always #5 clk_i = ~clk_i;

  function automatic longint sext(longint x, int w);
    return x[w-1] ? x - (longint'(1) << w) : x;
  endfunction

  function automatic logic is_bad(logic [3:0] op, logic [1:0] sz);
    return (op > 4'd9) || (sz == 2'd3) || (op == 4'd9 && sz == 2'd2);
  endfunction

  function automatic logic [63:0] model_res(logic [3:0] op, logic [1:0] sz,
                                            logic [63:0] a, logic [63:0] b, logic r);
    logic [63:0] out = '0;
    int w = 8 << sz;
    int n = 64 / w;
    longint m = (longint'(1) << w) - 1;
    if (is_bad(op, sz)) return '0;
    for (int i = 0; i < n; i++) begin
      longint x = longint'(a >> (i*w)) & m;
      longint y = longint'(b >> (i*w)) & m;
      longint sx = sext(x, w);
      longint sy = sext(y, w);
      longint v;
      case (op)
        4'd0: v = (x == y) ? m : 0;
        4'd1: v = (sx > sy) ? m : 0;
        4'd2: v = (x > y) ? m : 0;
        4'd3: v = (sx <= sy) ? x : y;
        4'd4: v = (x <= y) ? x : y;
        4'd5: v = (sx >= sy) ? x : y;
        4'd6: v = (x >= y) ? x : y;
        4'd7: v = (x + y) & m;
        4'd8: v = (x - y) & m;
        default: v = (x + y + longint'(r)) >> 1;
      endcase
      out = out | (64'(v & m) << (i*w));
    end
    return out;
  endfunction

  function automatic logic [31:0] model_flg(logic [3:0] op, logic [1:0] sz, logic [63:0] res);
    logic [31:0] f = '0;
    int w = 8 << sz;
    int n = 64 / w;
    int fw = 32 / n;
    if (is_bad(op, sz)) return '0;
    for (int i = 0; i < n; i++) begin
      logic [63:0] lane = (res >> (i*w)) & ((64'd1 << w) - 1);
      if (op != 4'd9 && lane[w-1]) f[i*fw + fw-1] = 1'b1;
      if (lane == 0) f[i*fw + fw-2] = 1'b1;
    end
    return f;
  endfunction

  task automatic run(input string tag, input logic [3:0] op, input logic [1:0] sz,
                     input logic [63:0] a, input logic [63:0] b, input logic r);
    logic [63:0] er = model_res(op, sz, a, b, r);
    logic [31:0] ef = model_flg(op, sz, er);
    logic        ei = is_bad(op, sz);
    @(negedge clk_i);
    op_i = op; size_i = sz; a_i = a; b_i = b; rnd_i = r;
    @(negedge clk_i);
    n_run++;
    if (res_o !== er || flags_o !== ef || illegal_o !== ei) begin
      n_fail++;
      $display("FAIL %s op=%0d sz=%0d: res=%h flg=%h ill=%b exp res=%h flg=%h ill=%b",
               tag, op, sz, res_o, flags_o, illegal_o, er, ef, ei);
    end
  endtask

  task automatic t_reset;
    n_run++;
    if (res_o !== 64'd0 || flags_o !== 32'd0 || illegal_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: res=%h flg=%h ill=%b exp 0 0 0", res_o, flags_o, illegal_o);
    end
  endtask

  task automatic t_latency;
    logic [63:0] prev;
    run("R2 setup", 4'd7, 2'd0, 64'h0101_0101_0101_0101, 64'h0101_0101_0101_0101, 1'b0);
    prev = res_o;
    @(negedge clk_i);
    op_i = 4'd8; size_i = 2'd0; a_i = 64'h0; b_i = 64'h1;
    #2;
    n_run++;
    if (res_o !== prev) begin
      n_fail++;
      $display("FAIL R2 early change: res=%h exp %h", res_o, prev);
    end
    @(negedge clk_i);
    n_run++;
    if (res_o !== 64'h0000_0000_0000_00ff) begin
      n_fail++;
      $display("FAIL R2 one-cycle: res=%h exp %h", res_o, 64'h0000_0000_0000_00ff);
    end
  endtask

  task automatic t_equal;
    run("R3 eq byte", 4'd0, 2'd0, 64'h1122_3344_5566_7788, 64'h1122_0044_5500_7788, 1'b0);
    run("R3 eq half", 4'd0, 2'd1, 64'hdead_beef_0000_1234, 64'hdead_beee_0000_1234, 1'b0);
    run("R3 eq word", 4'd0, 2'd2, 64'hffff_ffff_0000_0000, 64'hffff_ffff_0000_0001, 1'b0);
  endtask

  task automatic t_greater;
    for (int s = 0; s < 3; s++) begin
      run("R4 gts top", 4'd1, 2'(s), 64'h8000_0080_8080_8080, 64'h7fff_007f_7f7f_7f7f, 1'b0);
      run("R4 gtu top", 4'd2, 2'(s), 64'h8000_0080_8080_8080, 64'h7fff_007f_7f7f_7f7f, 1'b0);
    end
    run("R4 gts mix", 4'd1, 2'd0, 64'h01ff_7f80_0000_ff01, 64'hff01_807f_0001_01ff, 1'b0);
  endtask

  task automatic t_minmax;
    for (int s = 0; s < 3; s++) begin
      for (int op = 3; op <= 6; op++)
        run("R5 minmax", 4'(op), 2'(s), 64'h8000_0001_80ff_7f10, 64'h7fff_ffff_7f01_8020, 1'b0);
    end
  endtask

  task automatic t_addsub;
    run("R6 add byte wrap", 4'd7, 2'd0, 64'hff80_ff7f_00ff_01fe, 64'h0180_0101_ff01_ff02, 1'b0);
    run("R6 add half wrap", 4'd7, 2'd1, 64'hffff_8000_0001_ffff, 64'h0001_8000_ffff_0002, 1'b0);
    run("R6 sub byte borrow", 4'd8, 2'd0, 64'h0000_0100_0080_7f00, 64'h0100_0001_8001_8001, 1'b0);
    run("R6 sub word", 4'd8, 2'd2, 64'h0000_0000_0000_0005, 64'h0000_0001_0000_0006, 1'b0);
  endtask

  task automatic t_avg;
    run("R7 avg byte r0", 4'd9, 2'd0, 64'hff01_8000_fe03_0102, 64'hff00_8001_ff04_0000, 1'b0);
    run("R7 avg byte r1", 4'd9, 2'd0, 64'hff01_8000_fe03_0102, 64'hff00_8001_ff04_0000, 1'b1);
    run("R9 avg half top", 4'd9, 2'd1, 64'hffff_8000_0000_0001, 64'hffff_8000_0000_0000, 1'b1);
  endtask

  task automatic t_flags;
    run("R8 flags byte", 4'd8, 2'd0, 64'h8000_0001_ff00_1010, 64'h0000_0001_7f00_1011, 1'b0);
    run("R8 flags word", 4'd7, 2'd2, 64'h8000_0000_0000_0001, 64'h0000_0000_ffff_ffff, 1'b0);
  endtask

  task automatic t_illegal;
    run("R10 avg word", 4'd9, 2'd2, 64'h1234_5678_9abc_def0, 64'h1, 1'b1);
    run("R10 size3", 4'd7, 2'd3, 64'h1, 64'h1, 1'b0);
    run("R10 op10", 4'd10, 2'd0, 64'hff, 64'h1, 1'b0);
    run("R10 op15", 4'd15, 2'd1, 64'h5, 64'h5, 1'b0);
    run("R10 legal after", 4'd0, 2'd0, 64'h5, 64'h5, 1'b0);
  endtask

  initial begin
    fork
      begin
        #1;
        t_reset();
        #20;
        t_reset();
        @(negedge clk_i);
        rst_ni = 1'b1;
        t_latency();
        t_equal();
        t_greater();
        t_minmax();
        t_addsub();
        t_avg();
        t_flags();
        t_illegal();
      end
      begin
        repeat (20000) @(posedge clk_i);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule